// File: doc/BRIEF.md
# Page Translation Buffer with Hardware Table Walk

This block maps 32-bit virtual addresses to physical addresses for 4 KiB pages. Recent mappings are kept in a small set-associative store. A lookup that finds its page answers from the store alone. A lookup that misses starts a built-in walker. The walker reads one 32-bit entry from a flat page table in memory, at an address formed from a base input and the virtual page number. If the entry is usable, the walker installs it and then answers. If the entry is marked not present, the walker reports a page fault and installs nothing.

The block also keeps the reference and modified status of each page current. The walker writes the updated entry back to the table when that status changes. A write to a page whose entry forbids writing gets a protection fault instead of a translation.

A client presents one request at a time with a valid/ready handshake. It receives a single-cycle response carrying the physical address, a hit flag and the fault flags. A flush input drops every cached mapping at once.

Top module: `tlb_xlate`

## Requirements
- R1: On every response, `rsp_paddr[11:0]` equals bits 11:0 of the accepted virtual address. Bits 31:12 carry the physical page number on success and are zero on any fault.
- R2: When the page is cached, the response has `rsp_hit`=1 and no memory transaction takes place. The response is visible after the second rising edge, counting the accepting edge as the first.
- R3: On a miss, exactly one memory read is issued, at `pt_base + VPN*4`. The table entry layout is: present bit 31, modified bit 30, referenced bit 29, permission 28:27 (bit 28 = writing allowed), physical page 19:0. If the entry is present, the response has `rsp_hit`=0 and that page number, and the mapping is installed so that the next access to the page hits.
- R4: If the table entry has bit 31 = 0, the response has `rsp_fault`=1, `rsp_perm_err`=0 and `rsp_hit`=0, and nothing is installed, so a repeat access walks again.
- R5: After a successful walk, the entry is written back once to the same address if its referenced bit is 0, or if the access is a write and its modified bit is 0. The written word has bit 29 set, bit 30 set for a write, permission and page number kept, and bits 26:20 zero. An entry that already carries the needed bits is not written.
- R6: A write that hits a cached page not yet marked modified marks the page in the store and writes the entry back once with bits 31, 30 and 29 set. Later writes to that page cause no memory traffic.
- R7: A write to a page whose entry has bit 28 = 0 gives `rsp_fault`=1 and `rsp_perm_err`=1, with no memory write and no install. `rsp_hit` is 1 if the page was cached and 0 otherwise.
- R8: The store has 8 sets of 4 ways, and the set is chosen by VPN bits 2:0. A refill fills an empty way first, otherwise it replaces the least recently used way of the set.
- R9: A cycle with `flush` high invalidates every cached mapping, and `req_ready` is low during that cycle.
- R10: Only one request is in flight. `req_ready` is low from the accepting edge until the response has been given, and `rsp_valid` is a one-cycle pulse.
- R11: `mem_req` stays high with a stable address and direction until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all cached mappings |
| pt_base | input | 32 | Byte address of the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_hit | output | 1 | Mapping was found in the store |
| rsp_fault | output | 1 | Translation refused |
| rsp_perm_err | output | 1 | Refusal was a write-permission violation |
| mem_req | output | 1 | Page-table memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_wdata | output | 32 | Entry value being written back |
| mem_rdata | input | 32 | Entry value read, valid with ack |
| mem_ack | input | 1 | Memory access completed |

## Verification
The assertions watch, on every cycle, the invariants of the handshake and the store:
- a single request in flight and a one-cycle response pulse;
- a memory request held steady until it is acknowledged;
- no two ways matching the same page;
- the per-set age values always forming a permutation;
- an empty store after a flush;
- installs happening only on a miss;
- a page fault never reported as a hit.

Only the bench scenarios can show the rest:
- that the walker reads the right table address and uses the entry it reads;
- which way the replacement evicts;
- that status bits are written back exactly once, with the right word;
- that faulting walks leave nothing behind, which shows when a repeated access walks again.

// File: rtl/xlt_pkg.sv
// Shared widths, the page-table entry layout and walker states.
// Assumes 32-bit virtual and physical addresses and 4 KiB pages.
package xlt_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = 20;
    localparam int PERM_WR = 1;   // index of the write-allowed bit in the permission field

    typedef struct packed {
        logic             present;
        logic             modified;
        logic             referenced;
        logic [1:0]       perm;
        logic [6:0]       rsvd;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_READ,
        ST_WBACK
    } walk_st_e;
endpackage

// File: rtl/xlt_lru.sv
// Per-set least-recently-used tracking with one age value per way.
// Assumes WAYS is a power of two; ages in each set always form a permutation.
module xlt_lru
    import xlt_pkg::*;
#(
    parameter int SETS = 8,
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  q_set,
    input  logic                     touch_en,
    input  logic [$clog2(WAYS)-1:0]  touch_way,
    output logic [$clog2(WAYS)-1:0]  victim
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAYS-1:0]  age_mask [SETS];

    // Age update: touched way becomes youngest, younger ones grow older.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[q_set][w] <= '0;
                else if (age_q[q_set][w] < age_q[q_set][touch_way])
                    age_q[q_set][w] <= age_q[q_set][w] + 1'b1;
            end
        end
    end

    // Victim choice: the way holding the oldest age in the queried set.
    always_comb begin
        victim = '0;
        for (int w = 0; w < WAYS; w++)
            if (age_q[q_set][w] == WAY_W'(WAYS - 1))
                victim = WAY_W'(w);
    end

    // Decoded age coverage per set, used only by the permutation check.
    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            age_mask[s] = '0;
            for (int w = 0; w < WAYS; w++)
                age_mask[s][age_q[s][w]] = 1'b1;
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        AST_LRU_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
            age_mask[s] == {WAYS{1'b1}}) else $error("age permutation broken"); // R8
    end

    logic unused_idx;
    assign unused_idx = ^IDX_W;
endmodule

// File: rtl/xlt_store.sv
// Mapping store: per set and way a valid bit, tag, page number,
// modified and referenced bits and permission. Combinational lookup.
// Assumes install and mark requests address the set of lk_vpn.
module xlt_store
    import xlt_pkg::*;
#(
    parameter int SETS = 8,
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [VPN_W-1:0]         lk_vpn,
    output logic                     lk_hit,
    output logic [$clog2(WAYS)-1:0]  lk_way,
    output logic [PPN_W-1:0]         lk_ppn,
    output logic                     lk_dirty,
    output logic [1:0]               lk_perm,
    output logic                     free_found,
    output logic [$clog2(WAYS)-1:0]  free_way,
    input  logic                     ins_en,
    input  logic [$clog2(WAYS)-1:0]  ins_way,
    input  logic [PPN_W-1:0]         ins_ppn,
    input  logic                     ins_dirty,
    input  logic [1:0]               ins_perm,
    input  logic                     md_en,
    input  logic [$clog2(WAYS)-1:0]  md_way
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  dty_q [SETS];
    logic [WAYS-1:0]  ref_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q [SETS][WAYS];
    logic [1:0]       prm_q [SETS][WAYS];

    logic [IDX_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  hit_vec;
    logic             any_vld;

    assign lk_set = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    // Hit selection and lowest empty way of the looked-up set.
    always_comb begin
        lk_hit     = |hit_vec;
        lk_way     = '0;
        lk_ppn     = '0;
        lk_dirty   = 1'b0;
        lk_perm    = '0;
        free_found = 1'b0;
        free_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                lk_way   = WAY_W'(w);
                lk_ppn   = ppn_q[lk_set][w];
                lk_dirty = dty_q[lk_set][w];
                lk_perm  = prm_q[lk_set][w];
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_q[lk_set][w]) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
    end

    // Status bits: flush clears valid, install sets it, mark sets modified.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                dty_q[s] <= '0;
                ref_q[s] <= '0;
            end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++)
                vld_q[s] <= '0;
        end else if (ins_en) begin
            vld_q[lk_set][ins_way] <= 1'b1;
            ref_q[lk_set][ins_way] <= 1'b1;
            dty_q[lk_set][ins_way] <= ins_dirty;
        end else if (md_en) begin
            dty_q[lk_set][md_way] <= 1'b1;
        end
    end

    // Payload fields: written on install only.
    always_ff @(posedge clk) begin
        if (ins_en) begin
            tag_q[lk_set][ins_way] <= lk_tag;
            ppn_q[lk_set][ins_way] <= ins_ppn;
            prm_q[lk_set][ins_way] <= ins_perm;
        end
    end

    // Any valid entry anywhere, for the flush check.
    always_comb begin
        any_vld = 1'b0;
        for (int s = 0; s < SETS; s++)
            any_vld = any_vld | (|vld_q[s]);
    end

    logic unused_ref;
    assign unused_ref = ^ref_q[0];

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)) else $error("two ways match one page"); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !any_vld) else $error("entries survive flush"); // R9
    AST_INSTALL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !lk_hit) else $error("install over a hit"); // R3
endmodule

// File: rtl/xlt_walker.sv
// Request sequencing and table walk: lookup, refill, status write-back,
// fault classification and the registered response.
// Assumes a memory that holds mem_req until it answers with a one-cycle mem_ack.
module xlt_walker
    import xlt_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [VA_W-1:0]          pt_base,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [VA_W-1:0]          req_vaddr,
    input  logic                     req_write,
    output logic                     rsp_valid,
    output logic [VA_W-1:0]          rsp_paddr,
    output logic                     rsp_hit,
    output logic                     rsp_fault,
    output logic                     rsp_perm_err,
    output logic [VPN_W-1:0]         lk_vpn,
    input  logic                     lk_hit,
    input  logic [$clog2(WAYS)-1:0]  lk_way,
    input  logic [PPN_W-1:0]         lk_ppn,
    input  logic                     lk_dirty,
    input  logic [1:0]               lk_perm,
    input  logic                     free_found,
    input  logic [$clog2(WAYS)-1:0]  free_way,
    input  logic [$clog2(WAYS)-1:0]  victim,
    output logic                     ins_en,
    output logic [$clog2(WAYS)-1:0]  ins_way,
    output logic [PPN_W-1:0]         ins_ppn,
    output logic                     ins_dirty,
    output logic [1:0]               ins_perm,
    output logic                     md_en,
    output logic                     touch_en,
    output logic [$clog2(WAYS)-1:0]  touch_way,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [VA_W-1:0]          mem_addr,
    output logic [VA_W-1:0]          mem_wdata,
    input  logic [VA_W-1:0]          mem_rdata,
    input  logic                     mem_ack
);
    localparam int PAD_W = VA_W - VPN_W - 2;

    walk_st_e         st_q;
    logic [VA_W-1:0]  q_va;
    logic             q_wr;
    logic [PPN_W-1:0] q_ppn;
    logic             q_hit;
    pte_t             wb_q;
    pte_t             rd_pte;
    logic             look_perm_bad;
    logic             rd_perm_bad;

    assign rd_pte        = pte_t'(mem_rdata);
    assign lk_vpn        = q_va[VA_W-1:OFF_W];
    assign look_perm_bad = q_wr && !lk_perm[PERM_WR];
    assign rd_perm_bad   = q_wr && !rd_pte.perm[PERM_WR];
    assign mem_addr      = pt_base + {{PAD_W{1'b0}}, lk_vpn, 2'b00};
    assign mem_wdata     = wb_q;
    assign ins_way       = free_found ? free_way : victim;
    assign ins_ppn       = rd_pte.ppn;
    assign ins_dirty     = rd_pte.modified | q_wr;
    assign ins_perm      = rd_pte.perm;

    logic unused_rsvd;
    assign unused_rsvd = ^rd_pte.rsvd;

    // Per-state strobes toward the store, the age tracker and memory.
    always_comb begin
        req_ready = (st_q == ST_IDLE) && !flush;
        ins_en    = 1'b0;
        md_en     = 1'b0;
        touch_en  = 1'b0;
        touch_way = lk_way;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        case (st_q)
            ST_LOOK: begin
                if (lk_hit && !look_perm_bad) begin
                    touch_en = 1'b1;
                    md_en    = q_wr && !lk_dirty;
                end
            end
            ST_READ: begin
                mem_req = 1'b1;
                if (mem_ack && rd_pte.present && !rd_perm_bad) begin
                    ins_en    = 1'b1;
                    touch_en  = 1'b1;
                    touch_way = ins_way;
                end
            end
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    // Sequencing, captured request, pending write-back word and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            q_va         <= '0;
            q_wr         <= 1'b0;
            q_ppn        <= '0;
            q_hit        <= 1'b0;
            wb_q         <= '0;
            rsp_valid    <= 1'b0;
            rsp_paddr    <= '0;
            rsp_hit      <= 1'b0;
            rsp_fault    <= 1'b0;
            rsp_perm_err <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid && req_ready) begin
                        q_va <= req_vaddr;
                        q_wr <= req_write;
                        st_q <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (!lk_hit) begin
                        st_q <= ST_READ;
                    end else if (look_perm_bad) begin
                        rsp_valid    <= 1'b1;
                        rsp_paddr    <= {{PPN_W{1'b0}}, q_va[OFF_W-1:0]};
                        rsp_hit      <= 1'b1;
                        rsp_fault    <= 1'b1;
                        rsp_perm_err <= 1'b1;
                        st_q         <= ST_IDLE;
                    end else if (q_wr && !lk_dirty) begin
                        wb_q  <= '{present: 1'b1, modified: 1'b1, referenced: 1'b1,
                                   perm: lk_perm, rsvd: '0, ppn: lk_ppn};
                        q_ppn <= lk_ppn;
                        q_hit <= 1'b1;
                        st_q  <= ST_WBACK;
                    end else begin
                        rsp_valid    <= 1'b1;
                        rsp_paddr    <= {lk_ppn, q_va[OFF_W-1:0]};
                        rsp_hit      <= 1'b1;
                        rsp_fault    <= 1'b0;
                        rsp_perm_err <= 1'b0;
                        st_q         <= ST_IDLE;
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        if (!rd_pte.present || rd_perm_bad) begin
                            rsp_valid    <= 1'b1;
                            rsp_paddr    <= {{PPN_W{1'b0}}, q_va[OFF_W-1:0]};
                            rsp_hit      <= 1'b0;
                            rsp_fault    <= 1'b1;
                            rsp_perm_err <= rd_pte.present;
                            st_q         <= ST_IDLE;
                        end else if (!rd_pte.referenced || (q_wr && !rd_pte.modified)) begin
                            wb_q  <= '{present: 1'b1, modified: rd_pte.modified | q_wr,
                                       referenced: 1'b1, perm: rd_pte.perm, rsvd: '0,
                                       ppn: rd_pte.ppn};
                            q_ppn <= rd_pte.ppn;
                            q_hit <= 1'b0;
                            st_q  <= ST_WBACK;
                        end else begin
                            rsp_valid    <= 1'b1;
                            rsp_paddr    <= {rd_pte.ppn, q_va[OFF_W-1:0]};
                            rsp_hit      <= 1'b0;
                            rsp_fault    <= 1'b0;
                            rsp_perm_err <= 1'b0;
                            st_q         <= ST_IDLE;
                        end
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        rsp_valid    <= 1'b1;
                        rsp_paddr    <= {q_ppn, q_va[OFF_W-1:0]};
                        rsp_hit      <= q_hit;
                        rsp_fault    <= 1'b0;
                        rsp_perm_err <= 1'b0;
                        st_q         <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready) else $error("second request accepted"); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid) else $error("response longer than one cycle"); // R10
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
        else $error("memory request dropped or changed"); // R11
    AST_PFAULT_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && !rsp_perm_err) |-> !rsp_hit)
        else $error("page fault flagged as hit"); // R4
    AST_PERM_IS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm_err) |-> rsp_fault)
        else $error("protection error without fault"); // R7
endmodule

// File: rtl/tlb_xlate.sv
// Top level: connects the walker, the mapping store and the age tracker.
// Assumes pt_base is stable while a walk is in progress.
module tlb_xlate
    import xlt_pkg::*;
#(
    parameter int SETS = 8,
    parameter int WAYS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic [31:0] pt_base,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        req_write,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic        rsp_hit,
    output logic        rsp_fault,
    output logic        rsp_perm_err,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic [VPN_W-1:0] lk_vpn;
    logic             lk_hit, lk_dirty, free_found;
    logic [WAY_W-1:0] lk_way, free_way, victim, ins_way, touch_way;
    logic [PPN_W-1:0] lk_ppn, ins_ppn;
    logic [1:0]       lk_perm, ins_perm;
    logic             ins_en, ins_dirty, md_en, touch_en;

    xlt_walker #(.WAYS(WAYS)) u_walker (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_perm_err(rsp_perm_err),
        .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_way(lk_way), .lk_ppn(lk_ppn),
        .lk_dirty(lk_dirty), .lk_perm(lk_perm), .free_found(free_found),
        .free_way(free_way), .victim(victim), .ins_en(ins_en), .ins_way(ins_way),
        .ins_ppn(ins_ppn), .ins_dirty(ins_dirty), .ins_perm(ins_perm),
        .md_en(md_en), .touch_en(touch_en), .touch_way(touch_way),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    xlt_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_way(lk_way), .lk_ppn(lk_ppn), .lk_dirty(lk_dirty),
        .lk_perm(lk_perm), .free_found(free_found), .free_way(free_way),
        .ins_en(ins_en), .ins_way(ins_way), .ins_ppn(ins_ppn),
        .ins_dirty(ins_dirty), .ins_perm(ins_perm), .md_en(md_en), .md_way(lk_way)
    );

    xlt_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst_n(rst_n), .q_set(lk_vpn[IDX_W-1:0]),
        .touch_en(touch_en), .touch_way(touch_way), .victim(victim)
    );
endmodule

// File: tb/tlb_xlate_bench.sv
// Scoreboard bench: the driver queues the expected response, and a monitor
// compares it at each response pulse. The memory model gives every entry an
// initial value derived from its page number, plus the words written back.
module tlb_xlate_bench;
    localparam logic [31:0] BASE = 32'h0004_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] pt_base = BASE;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_perm_err;
    logic [31:0] rsp_paddr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int acc_cyc = 0;
    bit done = 1'b0;

    logic [34:0] sb_q[$];
    string       sb_tag[$];
    int          sb_lat[$];

    int          rd_cnt, wr_cnt, lat;
    logic [31:0] last_addr;
    logic [31:0] wb_val [64];
    logic [63:0] wb_has;

    always #10 clk = ~clk;

    tlb_xlate u_tlb_xlate (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_perm_err(rsp_perm_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [19:0] ppn_of(input logic [19:0] vpn);
        return 20'hA0000 ^ (vpn * 20'd7);
    endfunction

    // Page kinds by VPN[5:3]: 111 absent, 110 read-only, 101 already referenced+modified.
    function automatic logic [31:0] pte_init(input logic [19:0] vpn);
        logic [2:0] k;
        k = vpn[5:3];
        if (k == 3'b111) return {1'b0, 11'b0, ppn_of(vpn)};
        if (k == 3'b110) return {1'b1, 1'b0, 1'b0, 2'b01, 7'b0, ppn_of(vpn)};
        if (k == 3'b101) return {1'b1, 1'b1, 1'b1, 2'b11, 7'b0, ppn_of(vpn)};
        return {1'b1, 1'b0, 1'b0, 2'b11, 7'b0, ppn_of(vpn)};
    endfunction

    always_ff @(posedge clk) cyc <= cyc + 1;

    // Memory model: fixed latency, one-cycle acknowledge, write-back overlay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; mem_rdata <= '0; lat <= 0;
            rd_cnt <= 0; wr_cnt <= 0; last_addr <= '0; wb_has <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (lat == 2) begin
                    logic [5:0] ix;
                    ix = mem_addr[7:2];
                    lat <= 0;
                    mem_ack <= 1'b1;
                    last_addr <= mem_addr;
                    if (mem_we) begin
                        wb_val[ix] <= mem_wdata;
                        wb_has[ix] <= 1'b1;
                        wr_cnt <= wr_cnt + 1;
                    end else begin
                        mem_rdata <= wb_has[ix] ? wb_val[ix] : pte_init({14'b0, ix});
                        rd_cnt <= rd_cnt + 1;
                    end
                end else begin
                    lat <= lat + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare each response pulse.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10 unexpected response", {29'b0, rsp_hit, rsp_fault, rsp_perm_err, rsp_paddr}, 64'h0);
            end else begin
                logic [34:0] e;
                string t;
                int l;
                e = sb_q.pop_front();
                t = sb_tag.pop_front();
                l = sb_lat.pop_front();
                check({rsp_hit, rsp_fault, rsp_perm_err, rsp_paddr} == e, t,
                      {29'b0, rsp_hit, rsp_fault, rsp_perm_err, rsp_paddr}, {29'b0, e});
                if (l >= 0)
                    check((cyc - acc_cyc) == l, {t, " latency"}, 64'(cyc - acc_cyc), 64'(l));
            end
        end
    end

    // Driver: queue the expectation, present the request, wait for its answer.
    task automatic xlate(input logic [19:0] vpn, input logic [11:0] off, input bit wr,
                         input bit ehit, input bit efault, input bit eperm,
                         input string tag, input int elat);
        logic [19:0] ep;
        ep = efault ? 20'h0 : ppn_of(vpn);
        sb_q.push_back({ehit, efault, eperm, ep, off});
        sb_tag.push_back(tag);
        sb_lat.push_back(elat);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {vpn, off};
        req_write = wr;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        acc_cyc = cyc;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(!req_ready, "R10 ready low while busy", 64'(req_ready), 64'h0);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        int r0, w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req, "R10 reset state",
              {61'b0, req_ready, rsp_valid, mem_req}, 64'h4);

        // Refill of a fresh page, reference write-back.
        r0 = rd_cnt; w0 = wr_cnt;
        xlate(20'd1, 12'h234, 1'b0, 1'b0, 1'b0, 1'b0, "R3 refill read", -1);
        check(rd_cnt == r0 + 1, "R3 one table read", 64'(rd_cnt - r0), 64'd1);
        check(last_addr == BASE + 32'd4, "R3 table address", 64'(last_addr), 64'(BASE + 32'd4));
        check(wr_cnt == w0 + 1 && wb_val[1] == (pte_init(20'd1) | 32'h2000_0000),
              "R5 reference write-back", 64'(wb_val[1]), 64'(pte_init(20'd1) | 32'h2000_0000));

        // Hit with offset boundary, no memory traffic, fixed latency.
        r0 = rd_cnt; w0 = wr_cnt;
        xlate(20'd1, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0, "R1 R2 hit read", 2);
        check(rd_cnt == r0 && wr_cnt == w0, "R2 hit no memory", 64'(rd_cnt - r0 + wr_cnt - w0), 64'd0);

        // Write hit on a clean page, then a second write.
        w0 = wr_cnt;
        xlate(20'd1, 12'h000, 1'b1, 1'b1, 1'b0, 1'b0, "R6 write hit clean", -1);
        check(wr_cnt == w0 + 1 && wb_val[1] == (pte_init(20'd1) | 32'h6000_0000),
              "R6 modified write-back", 64'(wb_val[1]), 64'(pte_init(20'd1) | 32'h6000_0000));
        w0 = wr_cnt;
        xlate(20'd1, 12'h010, 1'b1, 1'b1, 1'b0, 1'b0, "R6 write hit dirty", 2);
        check(wr_cnt == w0, "R6 no second write-back", 64'(wr_cnt - w0), 64'd0);

        // Absent page: fault, nothing installed.
        r0 = rd_cnt;
        xlate(20'd56, 12'h080, 1'b0, 1'b0, 1'b1, 1'b0, "R4 page fault", -1);
        xlate(20'd56, 12'h084, 1'b0, 1'b0, 1'b1, 1'b0, "R4 repeat fault", -1);
        check(rd_cnt == r0 + 2, "R4 walks again", 64'(rd_cnt - r0), 64'd2);

        // Read-only page: write refused on walk and on hit.
        w0 = wr_cnt;
        xlate(20'd48, 12'h100, 1'b1, 1'b0, 1'b1, 1'b1, "R7 protection on walk", -1);
        check(wr_cnt == w0, "R7 no write on walk fault", 64'(wr_cnt - w0), 64'd0);
        xlate(20'd48, 12'h104, 1'b0, 1'b0, 1'b0, 1'b0, "R7 read of read-only page", -1);
        w0 = wr_cnt;
        xlate(20'd48, 12'h108, 1'b1, 1'b1, 1'b1, 1'b1, "R7 protection on hit", -1);
        check(wr_cnt == w0, "R7 no write on hit fault", 64'(wr_cnt - w0), 64'd0);

        // Entry already referenced and modified: no write-back.
        w0 = wr_cnt;
        xlate(20'd40, 12'h3C0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 refill no write-back", -1);
        check(wr_cnt == w0, "R5 status already set", 64'(wr_cnt - w0), 64'd0);

        // Replacement in set 2 (VPN[2:0]=010).
        xlate(20'd2,  12'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 fill way", -1);
        xlate(20'd10, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 fill way", -1);
        xlate(20'd18, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 fill way", -1);
        xlate(20'd26, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 fill way", -1);
        xlate(20'd2,  12'h4, 1'b0, 1'b1, 1'b0, 1'b0, "R8 touch", -1);
        xlate(20'd18, 12'h4, 1'b0, 1'b1, 1'b0, 1'b0, "R8 touch", -1);
        xlate(20'd26, 12'h4, 1'b0, 1'b1, 1'b0, 1'b0, "R8 touch", -1);
        xlate(20'd34, 12'h8, 1'b0, 1'b0, 1'b0, 1'b0, "R8 fifth page", -1);
        xlate(20'd2,  12'hC, 1'b0, 1'b1, 1'b0, 1'b0, "R8 survivor hit", -1);
        xlate(20'd18, 12'hC, 1'b0, 1'b1, 1'b0, 1'b0, "R8 survivor hit", -1);
        xlate(20'd26, 12'hC, 1'b0, 1'b1, 1'b0, 1'b0, "R8 survivor hit", -1);
        xlate(20'd34, 12'hC, 1'b0, 1'b1, 1'b0, 1'b0, "R8 new page hit", -1);
        xlate(20'd10, 12'hC, 1'b0, 1'b0, 1'b0, 1'b0, "R8 oldest evicted", -1);

        // Flush.
        @(negedge clk);
        flush = 1'b1;
        #1;
        check(!req_ready, "R9 ready low during flush", 64'(req_ready), 64'h0);
        @(negedge clk);
        flush = 1'b0;
        xlate(20'd2, 12'h020, 1'b0, 1'b0, 1'b0, 1'b0, "R9 miss after flush", -1);
        xlate(20'd2, 12'h024, 1'b0, 1'b1, 1'b0, 1'b0, "R9 refilled after flush", -1);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule